// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block is the control unit of a small 8-bit accumulator machine. It holds a step counter that advances once per clock. It pairs the step number with the opcode held in the instruction register and looks the pair up in a microcode table. The table entry is the set of control strobes for that cycle. The datapath registers, program memory, data memory and adder sit outside the block and act on these strobes.

Each table entry has two parts. One part is a group of independent strobes that may be asserted in any combination: program-counter increment, program-counter jump, flag load and step-counter clear. The other part is two 3-bit fields. One field selects which unit drives the shared bus and the other selects which unit loads from it. Each field passes through a 3-to-8 decoder, so each field asserts at most one strobe. Code 0 of a field asserts nothing.

An instruction does not run for a fixed number of cycles. Its last microstep asserts the clear strobe, and the counter returns to step 0 on the next clock. The counter allows up to `STEPS` steps (20 by default). All defined instructions finish by step 6.

Top module: `ctrl_seq`

## Requirements
- R1: With `rst` high at a rising edge, `tstate` is 0 after that edge. This holds when reset arrives in the middle of an instruction.
- R2: For every opcode, step 0 drives the bus from the program counter and loads the address register. Step 1 drives the bus from program memory, loads the instruction register and asserts `pc_inc`.
- R3: `tstate` rises by exactly one on each clock while `tstate_clr` is low. After a clock with `tstate_clr` high it is 0.
- R4: NOP (opcode 0) asserts only `tstate_clr` in step 2.
- R5: JP (opcode 1) uses program counter to address register in step 2, program memory to bus with `pc_jump` in step 3, and clear in step 4.
- R6: LDA (2) and LDB (3) use program counter to address register in step 2. In step 3 they load program memory into A (LDA) or B (LDB) with `pc_inc`, and they clear in step 4.
- R7: ADD (4) asserts nothing in step 2. Step 3 has adder to bus, T load and `flags_ld`. Step 4 moves T to A. Step 5 clears.
- R8: TAB (5), TBA (6) and TAO (7) do one transfer in step 2 (A to B, B to A, A to output respectively) and clear in step 3.
- R9: STA (8), LRA (9), STB (10) and LRB (11) have these steps:
  - step 2: program counter to address register;
  - step 3: program memory into T;
  - step 4: T into the address register;
  - step 5: A to data memory (STA), data memory to A (LRA), B to data memory (STB) or data memory to B (LRB), each with `pc_inc`;
  - step 6: clear.
- R10: Opcodes 12 to 15 produce the same strobes as NOP at every step.
- R11: At most one bit of `bus_src` and at most one bit of `bus_dst` is high in any cycle.
- R12: A step with no table entry asserts no strobe. After step `STEPS`-1 the counter wraps to 0 even when clear is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the step counter moves on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode from the instruction register |
| tstate | output | $clog2(STEPS) | Current step number |
| pc_inc | output | 1 | Program-counter increment |
| pc_jump | output | 1 | Program counter loads from the bus |
| flags_ld | output | 1 | Flag register loads the adder flags |
| tstate_clr | output | 1 | Last microstep: counter returns to 0 next clock |
| bus_src | output | 7 | One-hot bus driver. Bits 0 to 6 select, in order: PC, program memory, data memory, A, B, adder, T |
| bus_dst | output | 7 | One-hot bus loader. Bits 0 to 6 select, in order: address register, instruction register, A, B, T, output, data memory |

## Verification
The bench runs every one of the sixteen opcodes through its whole sequence and compares each strobe group with a behavioural table on every cycle. A table entry placed one step early or late, or a clear that is missing, would show up as a sequence that is too short or too long. A wrong field code would light the wrong bus line, or two lines at once. It also swaps the opcode to NOP partway through a memory instruction. This lands on an empty step, and the bench checks that the counter runs to its last step and wraps. A counter bound that is off by one would wrap one step early or run past the bound. Reset is pulsed in the middle of an instruction, and the bench checks that `tstate` drops to 0 at once and not at the end of the instruction.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;

  localparam int OPW = 4;   // opcode width
  localparam int FW  = 3;   // width of each encoded bus field

  typedef enum logic [OPW-1:0] {
    OP_NOP = 4'd0,  OP_JP  = 4'd1,  OP_LDA = 4'd2,  OP_LDB = 4'd3,
    OP_ADD = 4'd4,  OP_TAB = 4'd5,  OP_TBA = 4'd6,  OP_TAO = 4'd7,
    OP_STA = 4'd8,  OP_LRA = 4'd9,  OP_STB = 4'd10, OP_LRB = 4'd11
  } op_e;

  // bus driver field; code k lights bus_src[k-1]
  typedef enum logic [FW-1:0] {
    SRC_NONE, SRC_PC, SRC_ROM, SRC_RAM, SRC_A, SRC_B, SRC_ALU, SRC_T
  } src_e;

  // bus loader field; code k lights bus_dst[k-1]
  typedef enum logic [FW-1:0] {
    DST_NONE, DST_MAR, DST_IR, DST_A, DST_B, DST_T, DST_OUT, DST_RAM
  } dst_e;

  typedef struct packed {
    dst_e dst;
    src_e src;
    logic clr;
    logic flags;
    logic jump;
    logic inc;
  } uword_t;

endpackage

// File: rtl/tstate_ctr.sv
module tstate_ctr #(
  parameter int  STEPS = 20,
  localparam int TW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [TW-1:0] step
);
  localparam logic [TW-1:0] LAST = TW'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      step <= '0;
    else if (clr || step == LAST)
      step <= '0;
    else
      step <= step + 1'b1;
  end
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
  import ctrl_seq_pkg::*;
#(
  parameter int  STEPS = 20,
  localparam int TW    = $clog2(STEPS)
) (
  input  logic [OPW-1:0] opcode,
  input  logic [TW-1:0]  step,
  output uword_t         uw
);
  int  s;
  op_e op;

  always_comb begin
    uw = '0;
    s  = int'(step);
    op = op_e'(opcode);
    if (s == 0) begin
      uw.src = SRC_PC;  uw.dst = DST_MAR;
    end else if (s == 1) begin
      uw.src = SRC_ROM; uw.dst = DST_IR; uw.inc = 1'b1;
    end else begin
      case (op)
        OP_JP, OP_LDA, OP_LDB: begin
          case (s)
            2: begin uw.src = SRC_PC; uw.dst = DST_MAR; end
            3: begin
              uw.src = SRC_ROM;
              if (op == OP_JP) uw.jump = 1'b1;
              else begin
                uw.inc = 1'b1;
                uw.dst = (op == OP_LDA) ? DST_A : DST_B;
              end
            end
            4: uw.clr = 1'b1;
            default: ;
          endcase
        end
        OP_ADD: begin
          case (s)
            3: begin uw.src = SRC_ALU; uw.dst = DST_T; uw.flags = 1'b1; end
            4: begin uw.src = SRC_T;   uw.dst = DST_A; end
            5: uw.clr = 1'b1;
            default: ;
          endcase
        end
        OP_TAB, OP_TBA, OP_TAO: begin
          case (s)
            2: begin
              uw.src = (op == OP_TBA) ? SRC_B : SRC_A;
              uw.dst = (op == OP_TAB) ? DST_B : (op == OP_TBA) ? DST_A : DST_OUT;
            end
            3: uw.clr = 1'b1;
            default: ;
          endcase
        end
        OP_STA, OP_LRA, OP_STB, OP_LRB: begin
          case (s)
            2: begin uw.src = SRC_PC;  uw.dst = DST_MAR; end
            3: begin uw.src = SRC_ROM; uw.dst = DST_T; end
            4: begin uw.src = SRC_T;   uw.dst = DST_MAR; end
            5: begin
              uw.inc = 1'b1;
              case (op)
                OP_STA:  begin uw.src = SRC_A;   uw.dst = DST_RAM; end
                OP_STB:  begin uw.src = SRC_B;   uw.dst = DST_RAM; end
                OP_LRA:  begin uw.src = SRC_RAM; uw.dst = DST_A;   end
                default: begin uw.src = SRC_RAM; uw.dst = DST_B;   end
              endcase
            end
            6: uw.clr = 1'b1;
            default: ;
          endcase
        end
        default: begin   // NOP and every undefined code
          if (s == 2) uw.clr = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/field_dec.sv
module field_dec #(
  parameter int  FW = 3,
  localparam int NL = (1 << FW) - 1
) (
  input  logic [FW-1:0] code,
  output logic [NL-1:0] lines
);
  // code 0 is idle; code k drives lines[k-1]
  for (genvar k = 1; k <= NL; k++) begin : g_line
    assign lines[k-1] = (code == FW'(k));
  end
endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_seq_pkg::*;
#(
  parameter int  STEPS = 20,
  localparam int TW    = $clog2(STEPS),
  localparam int NL    = (1 << FW) - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [TW-1:0]  tstate,
  output logic           pc_inc,
  output logic           pc_jump,
  output logic           flags_ld,
  output logic           tstate_clr,
  output logic [NL-1:0]  bus_src,
  output logic [NL-1:0]  bus_dst
);
  uword_t        uw;
  logic [FW-1:0] fcode [2];
  logic [NL-1:0] fline [2];

  tstate_ctr #(.STEPS(STEPS)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (uw.clr),
    .step (tstate)
  );

  ucode_rom #(.STEPS(STEPS)) u_rom (
    .opcode (opcode),
    .step   (tstate),
    .uw     (uw)
  );

  assign fcode[0] = uw.src;
  assign fcode[1] = uw.dst;

  for (genvar g = 0; g < 2; g++) begin : g_field
    field_dec #(.FW(FW)) u_dec (
      .code  (fcode[g]),
      .lines (fline[g])
    );
  end

  assign bus_src    = fline[0];
  assign bus_dst    = fline[1];
  assign pc_inc     = uw.inc;
  assign pc_jump    = uw.jump;
  assign flags_ld   = uw.flags;
  assign tstate_clr = uw.clr;
endmodule

// File: rtl/ctrl_seq_chk.sv
module ctrl_seq_chk
  import ctrl_seq_pkg::*;
#(
  parameter int  STEPS = 20,
  localparam int TW    = $clog2(STEPS),
  localparam int NL    = (1 << FW) - 1
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] opcode,
  input logic [TW-1:0]  tstate,
  input logic           pc_inc,
  input logic           pc_jump,
  input logic           flags_ld,
  input logic           tstate_clr,
  input logic [NL-1:0]  bus_src,
  input logic [NL-1:0]  bus_dst
);
  localparam logic [TW-1:0] LAST = TW'(STEPS - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk) $fell(rst) |-> tstate == '0);
  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    tstate == '0 |-> (bus_src == NL'(1) && bus_dst == NL'(1) && !pc_inc));
  // R3
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tstate_clr |=> tstate == '0);
  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!tstate_clr && tstate != LAST) |=> tstate == $past(tstate) + 1'b1);
  // R5
  jump_source_chk: assert property (@(posedge clk) disable iff (rst)
    pc_jump |-> bus_src == NL'(2));
  // R7
  flags_path_chk: assert property (@(posedge clk) disable iff (rst)
    flags_ld |-> (bus_src == NL'(32) && bus_dst == NL'(16)));
  // R10
  undef_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode >= OPW'(12) && tstate == TW'(2)) |-> tstate_clr);
  // R11
  src_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_src));
  // R11
  dst_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_dst));
  // R12
  last_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tstate == LAST |=> tstate == '0);
  // R12
  step_bound_chk: assert property (@(posedge clk) disable iff (rst) tstate <= LAST);
endmodule

bind ctrl_seq ctrl_seq_chk #(.STEPS(STEPS)) u_chk (.*);

// File: tb/ctrl_seq_test.sv
module ctrl_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'd0;
  logic [4:0] tstate;
  logic       pc_inc, pc_jump, flags_ld, tstate_clr;
  logic [6:0] bus_src, bus_dst;

  int checks = 0, failures = 0, cycles = 0, max_seen = 0;
  int ref_t = 0;
  bit done = 0;

  ctrl_seq uut (
    .clk(clk), .rst(rst), .opcode(opcode), .tstate(tstate),
    .pc_inc(pc_inc), .pc_jump(pc_jump), .flags_ld(flags_ld),
    .tstate_clr(tstate_clr), .bus_src(bus_src), .bus_dst(bus_dst)
  );

  always #5 clk = ~clk;

  // expected strobes: src/dst codes 1..7 (0 = idle); par = {inc,jump,flags,clr}
  task automatic expect_at(input int op, input int t,
                           output int src, output int dst, output int par);
    int o;
    o = (op > 11) ? 0 : op;
    src = 0; dst = 0; par = 0;
    if (t == 0) begin src = 1; dst = 1; end
    else if (t == 1) begin src = 2; dst = 2; par = 8; end
    else if (o == 0) begin if (t == 2) par = 1; end
    else if (o <= 3) begin
      if (t == 2) begin src = 1; dst = 1; end
      if (t == 3) begin src = 2; if (o == 1) par = 4; else begin dst = o + 1; par = 8; end end
      if (t == 4) par = 1;
    end else if (o == 4) begin
      if (t == 3) begin src = 6; dst = 5; par = 2; end
      if (t == 4) begin src = 7; dst = 3; end
      if (t == 5) par = 1;
    end else if (o <= 7) begin
      if (t == 2) begin
        src = (o == 6) ? 5 : 4;
        dst = (o == 5) ? 4 : (o == 6) ? 3 : 6;
      end
      if (t == 3) par = 1;
    end else begin
      if (t == 2) begin src = 1; dst = 1; end
      if (t == 3) begin src = 2; dst = 5; end
      if (t == 4) begin src = 7; dst = 1; end
      if (t == 5) begin
        par = 8;
        if (o == 8)  begin src = 4; dst = 7; end
        if (o == 9)  begin src = 3; dst = 3; end
        if (o == 10) begin src = 5; dst = 7; end
        if (o == 11) begin src = 3; dst = 4; end
      end
      if (t == 6) par = 1;
    end
  endtask

  function automatic string req_of(input int op, input int t);
    if (t < 2) return "R2";
    if (t > 6) return "R12";
    if (op == 0) return "R4";
    if (op == 1) return "R5";
    if (op <= 3) return "R6";
    if (op == 4) return "R7";
    if (op <= 7) return "R8";
    if (op <= 11) return "R9";
    return "R10";
  endfunction

  function automatic logic [6:0] oh(input int code);
    return (code == 0) ? 7'd0 : 7'(1 << (code - 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (op=%0d t=%0d)", req, act, exp, opcode, ref_t);
    end
  endtask

  // reference step counter
  always @(posedge clk) begin
    int s, d, p;
    cycles++;
    expect_at(int'(opcode), ref_t, s, d, p);
    if (rst) ref_t = 0;
    else if (p[0] || ref_t == 19) ref_t = 0;
    else ref_t = ref_t + 1;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int s, d, p;
    if (!rst && !done) begin
      expect_at(int'(opcode), ref_t, s, d, p);
      check("R3", int'(tstate), ref_t);
      check(req_of(int'(opcode), ref_t), int'(bus_src), int'(oh(s)));
      check(req_of(int'(opcode), ref_t), int'(bus_dst), int'(oh(d)));
      check(req_of(int'(opcode), ref_t),
            int'({pc_inc, pc_jump, flags_ld, tstate_clr}), p);
      check("R11", int'($countones(bus_src) <= 1 && $countones(bus_dst) <= 1), 1);
      if (int'(tstate) > max_seen) max_seen = int'(tstate);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic run_op(input int op);
    opcode = 4'(op);
    step();
    while (ref_t != 0) step();
  endtask

  initial begin
    repeat (3) step();
    check("R1", int'(tstate), 0);
    rst = 1'b0;
    for (int op = 0; op < 16; op++) run_op(op);

    // R12: empty step reached by swapping to NOP mid-sequence
    opcode = 4'd8;
    while (ref_t != 5) step();
    opcode = 4'd0;
    step();
    while (ref_t != 0) step();
    check("R12", max_seen, 19);

    // R1: reset in the middle of LDA
    opcode = 4'd2;
    step();
    while (ref_t != 3) step();
    rst = 1'b1;
    step();
    check("R1", int'(tstate), 0);
    rst = 1'b0;
    run_op(2);
    run_op(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule